// File: doc/BRIEF.md
# Negative Fused Multiply-Add Special-Case Unit

This block finishes a binary64 negative multiply-add, -((A×C)+B). An external fused datapath does the multiply, add and single rounding and delivers its raw sum together with its overflow, underflow and inexact indications. This unit looks at the three operands and at that sum. It decides whether the answer is the sign-inverted sum, a quieted copy of an input NaN, or the default quiet NaN. It reports the invalid-operation causes as separate flags.

Each operation is presented with a one-cycle `in_valid` strobe. One clock later the unit registers the final value, the per-operation flags, the summary bits and an optional 4-bit condition field, and raises `out_valid`. A sticky record of every exception flag seen since reset is held inside, so the "new exception" summary bit reflects only flags that change from 0 to 1 in this operation. Outputs hold their values between strobes.

Top module: `fnma_special_unit`

## Requirements
- R1: When no operand is a NaN and no invalid case applies, the result equals `dp_result` with only bit 63 inverted.
- R2: When the selected arithmetic result `dp_result` is a NaN (exponent all ones, fraction non-zero), it is output unchanged, sign included.
- R3: If no operand is a NaN and one of A, C is a zero while the other is an infinity (either order, either signs), flag bit 4 (invalid zero-times-infinity) is set and the result is 0x7FF8000000000000.
- R4: If no operand is a NaN, A×C is an infinity (neither factor zero) and B is an infinity whose sign differs from sign(A) XOR sign(C), flag bit 3 (invalid infinity difference) is set and the result is 0x7FF8000000000000; infinities of matching sign raise nothing.
- R5: Any signalling NaN operand (exponent all ones, fraction bit 51 clear, fraction non-zero) sets flag bit 5; the propagated NaN has fraction bit 51 set and keeps its sign and remaining bits.
- R6: With NaN operands, the propagated NaN is taken from A first, then B, then C, and flag bits 4 and 3 stay clear even if a zero-times-infinity pattern is present.
- R7: A subnormal operand counts as non-zero: a subnormal times an infinity is not an invalid case.
- R8: `out_vx` is the OR of flag bits 5, 4 and 3; flag bits 2, 1, 0 (overflow, underflow, inexact) copy `dp_flags[2:0]` on the numeric path and are 0 whenever a NaN result is chosen by R3 to R6.
- R9: `out_fx` is 1 exactly when some flag bit of this operation was not set by any earlier operation since reset; reset clears that history.
- R10: `out_fex` is 1 when any of {VX, overflow, underflow, inexact} of this operation is 1 together with the matching bit of `en_mask` = {bit3 VX, bit2 overflow, bit1 underflow, bit0 inexact}.
- R11: When `rec_flag` is 1, `out_cr` loads {fx, fex, vx, overflow} (bit 3 down to bit 0) of this operation; when 0, `out_cr` keeps its value.
- R12: After reset all outputs are 0; `out_valid` is 1 in exactly the cycle after an `in_valid` cycle, and other outputs hold while `in_valid` is 0.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_a | input | 64 | Multiplicand A |
| op_c | input | 64 | Multiplier C |
| op_b | input | 64 | Addend B |
| dp_result | input | 64 | Rounded (A×C)+B from the datapath |
| dp_flags | input | 3 | Datapath {overflow, underflow, inexact} |
| rec_flag | input | 1 | Load condition field this operation |
| en_mask | input | 4 | Exception enables {VX, OX, UX, XX} |
| out_valid | output | 1 | Outputs updated this cycle |
| out_res | output | 64 | Final result |
| out_flags | output | 6 | {snan, zero×inf, inf-inf, ox, ux, xx} |
| out_vx | output | 1 | Any invalid flag |
| out_fx | output | 1 | New exception this operation |
| out_fex | output | 1 | Enabled exception this operation |
| out_cr | output | 4 | Condition field |

## Verification
The bench aims at NaN sign handling: a design that negates every result flips a NaN's sign bit, while one that checks the wrong value leaves numbers un-negated. It crosses zero-times-infinity with a NaN addend and with a subnormal factor, where a careless priority or a zero test ignoring the fraction raises a false invalid flag. Infinity pairs of matching and opposing effective sign catch an inverted sign compare. Repeated identical exceptions and a mid-run reset expose a new-exception bit that ignores history, and a cleared record flag catches a condition field that updates anyway.

// File: rtl/fnma_pkg.sv
package fnma_pkg;
    localparam int DW    = 64;
    localparam int EW    = 11;
    localparam int FW    = 52;
    localparam int NOPS  = 3;
    localparam int SBIT  = DW - 1;
    localparam int QBIT  = FW - 1;
    localparam int NFLG  = 6;
    localparam logic [DW-1:0] DEFAULT_QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};
    localparam logic [DW-1:0] SIGN_MASK    = {1'b1, {(DW-1){1'b0}}};

    typedef enum logic [2:0] {
        CL_ZERO, CL_SUB, CL_NORM, CL_INF, CL_QNAN, CL_SNAN
    } fp_class_e;

    typedef struct packed {
        logic      sign;
        fp_class_e cls;
    } op_info_t;

    typedef struct packed {
        logic vxsnan;
        logic vximz;
        logic vxisi;
        logic ox;
        logic ux;
        logic xx;
    } flags_t;

    function automatic fp_class_e classify(input logic [DW-1:0] v);
        logic [EW-1:0] e;
        logic [FW-1:0] f;
        e = v[DW-2 -: EW];
        f = v[FW-1:0];
        if (e == '0)
            return (f == '0) ? CL_ZERO : CL_SUB;
        else if (e == '1) begin
            if (f == '0)   return CL_INF;
            if (f[QBIT])   return CL_QNAN;
            return CL_SNAN;
        end
        return CL_NORM;
    endfunction

    function automatic logic is_nan(input fp_class_e c);
        return (c == CL_QNAN) || (c == CL_SNAN);
    endfunction

    function automatic logic [DW-1:0] quiet(input logic [DW-1:0] v);
        logic [DW-1:0] r;
        r = v;
        r[QBIT] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/fnma_classify.sv
module fnma_classify
    import fnma_pkg::*;
(
    input  logic [DW-1:0] val,
    output op_info_t      info
);
    always_comb begin
        info.sign = val[SBIT];
        info.cls  = classify(val);
    end
endmodule

// File: rtl/fnma_select.sv
module fnma_select
    import fnma_pkg::*;
(
    input  logic [NOPS-1:0][DW-1:0] ops,
    input  op_info_t [NOPS-1:0]     info,
    input  logic [DW-1:0]           dp_result,
    input  logic [2:0]              dp_flags,
    output logic [DW-1:0]           res,
    output flags_t                  flags
);
    localparam int IA = 0;
    localparam int IB = 1;
    localparam int IC = 2;

    logic          any_nan;
    logic          any_snan;
    logic [DW-1:0] nan_pick;
    logic          imz;
    logic          prod_inf;
    logic          prod_sign;
    logic          isi;
    logic          dp_is_nan;

    always_comb begin
        any_nan  = 1'b0;
        any_snan = 1'b0;
        nan_pick = DEFAULT_QNAN;
        for (int i = NOPS - 1; i >= 0; i--) begin
            if (is_nan(info[i].cls)) begin
                any_nan  = 1'b1;
                nan_pick = ops[i];
            end
            if (info[i].cls == CL_SNAN)
                any_snan = 1'b1;
        end
    end

    always_comb begin
        imz = ((info[IA].cls == CL_ZERO) && (info[IC].cls == CL_INF)) ||
              ((info[IA].cls == CL_INF)  && (info[IC].cls == CL_ZERO));
        prod_inf  = ((info[IA].cls == CL_INF) || (info[IC].cls == CL_INF)) && !imz;
        prod_sign = info[IA].sign ^ info[IC].sign;
        isi = prod_inf && (info[IB].cls == CL_INF) && (prod_sign != info[IB].sign);
        dp_is_nan = is_nan(classify(dp_result));
    end

    always_comb begin
        flags = '0;
        res   = DEFAULT_QNAN;
        if (any_nan) begin
            res          = quiet(nan_pick);
            flags.vxsnan = any_snan;
        end else if (imz) begin
            flags.vximz = 1'b1;
        end else if (isi) begin
            flags.vxisi = 1'b1;
        end else begin
            res      = dp_is_nan ? dp_result : (dp_result ^ SIGN_MASK);
            flags.ox = dp_flags[2];
            flags.ux = dp_flags[1];
            flags.xx = dp_flags[0];
        end
    end
endmodule

// File: rtl/fnma_status.sv
module fnma_status
    import fnma_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [DW-1:0]      res,
    input  flags_t             flags,
    input  logic               rec_flag,
    input  logic [3:0]         en_mask,
    output logic               out_valid,
    output logic [DW-1:0]      out_res,
    output logic [NFLG-1:0]    out_flags,
    output logic               out_vx,
    output logic               out_fx,
    output logic               out_fex,
    output logic [3:0]         out_cr
);
    logic [NFLG-1:0] seen_q;
    logic [NFLG-1:0] flag_vec;
    logic            vx;
    logic            fx;
    logic            fex;
    logic [3:0]      raised;

    always_comb begin
        flag_vec = flags;
        vx       = flags.vxsnan | flags.vximz | flags.vxisi;
        fx       = |(flag_vec & ~seen_q);
        raised   = {vx, flags.ox, flags.ux, flags.xx};
        fex      = |(raised & en_mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q    <= '0;
            out_valid <= 1'b0;
            out_res   <= '0;
            out_flags <= '0;
            out_vx    <= 1'b0;
            out_fx    <= 1'b0;
            out_fex   <= 1'b0;
            out_cr    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                seen_q    <= seen_q | flag_vec;
                out_res   <= res;
                out_flags <= flag_vec;
                out_vx    <= vx;
                out_fx    <= fx;
                out_fex   <= fex;
                if (rec_flag)
                    out_cr <= {fx, fex, vx, flags.ox};
            end
        end
    end
endmodule

// File: rtl/fnma_special_unit.sv
module fnma_special_unit
    import fnma_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [63:0]     op_a,
    input  logic [63:0]     op_c,
    input  logic [63:0]     op_b,
    input  logic [63:0]     dp_result,
    input  logic [2:0]      dp_flags,
    input  logic            rec_flag,
    input  logic [3:0]      en_mask,
    output logic            out_valid,
    output logic [63:0]     out_res,
    output logic [5:0]      out_flags,
    output logic            out_vx,
    output logic            out_fx,
    output logic            out_fex,
    output logic [3:0]      out_cr
);
    logic [NOPS-1:0][DW-1:0] ops;
    op_info_t [NOPS-1:0]     info;
    logic [DW-1:0]           sel_res;
    flags_t                  sel_flags;

    assign ops = {op_c, op_b, op_a};

    for (genvar g = 0; g < NOPS; g++) begin : g_cls
        fnma_classify u_cls (
            .val  (ops[g]),
            .info (info[g])
        );
    end

    fnma_select u_sel (
        .ops       (ops),
        .info      (info),
        .dp_result (dp_result),
        .dp_flags  (dp_flags),
        .res       (sel_res),
        .flags     (sel_flags)
    );

    fnma_status u_stat (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .res       (sel_res),
        .flags     (sel_flags),
        .rec_flag  (rec_flag),
        .en_mask   (en_mask),
        .out_valid (out_valid),
        .out_res   (out_res),
        .out_flags (out_flags),
        .out_vx    (out_vx),
        .out_fx    (out_fx),
        .out_fex   (out_fex),
        .out_cr    (out_cr)
    );
endmodule

// File: rtl/fnma_special_unit_chk.sv
module fnma_special_unit_chk
    import fnma_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [63:0] op_a,
    input logic [63:0] op_c,
    input logic [63:0] op_b,
    input logic [63:0] dp_result,
    input logic        rec_flag,
    input logic        out_valid,
    input logic [63:0] out_res,
    input logic [5:0]  out_flags,
    input logic        out_vx,
    input logic        out_fx,
    input logic        out_fex,
    input logic [3:0]  out_cr
);
    logic plain_ops;
    logic dp_nan;
    assign plain_ops = (op_a[62:52] != '1) && (op_b[62:52] != '1) && (op_c[62:52] != '1);
    assign dp_nan    = (dp_result[62:52] == '1) && (dp_result[51:0] != '0);

    assert_valid_rise_R12: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_idle_R12: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_res));
    assert_negate_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && plain_ops && !dp_nan) |=> (out_res == ($past(dp_result) ^ SIGN_MASK)));
    assert_nan_keep_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && plain_ops && dp_nan) |=> (out_res == $past(dp_result)));
    assert_default_nan_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_flags[4] || out_flags[3])) |-> (out_res == DEFAULT_QNAN));
    assert_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_flags[5]) |-> (out_res[62:52] == '1 && out_res[51]));
    assert_one_cause_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $onehot0(out_flags[5:3]));
    assert_vx_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_vx == (|out_flags[5:3])));
    assert_cr_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !rec_flag) |=> $stable(out_cr));
    assert_cr_load_R11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && rec_flag) |=> (out_cr == {out_fx, out_fex, out_vx, out_flags[2]}));
endmodule

bind fnma_special_unit fnma_special_unit_chk u_chk (.*);

// File: tb/fnma_special_unit_tb.sv
module fnma_special_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] ONE   = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] TWO   = 64'h4000_0000_0000_0000;
    localparam logic [63:0] PINF  = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] NINF  = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] QNAN0 = 64'h7FF8_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] op_a, op_c, op_b, dp_result;
    logic [2:0]  dp_flags;
    logic        rec_flag;
    logic [3:0]  en_mask;
    logic        out_valid;
    logic [63:0] out_res;
    logic [5:0]  out_flags;
    logic        out_vx, out_fx, out_fex;
    logic [3:0]  out_cr;

    int n_run  = 0;
    int n_fail = 0;
    logic [5:0] m_seen;
    logic [3:0] m_cr;

    always #(CLK_PERIOD/2) clk = ~clk;

    fnma_special_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .op_a(op_a), .op_c(op_c), .op_b(op_b),
        .dp_result(dp_result), .dp_flags(dp_flags),
        .rec_flag(rec_flag), .en_mask(en_mask),
        .out_valid(out_valid), .out_res(out_res), .out_flags(out_flags),
        .out_vx(out_vx), .out_fx(out_fx), .out_fex(out_fex), .out_cr(out_cr)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_seen = '0;
        m_cr   = '0;
    endtask

    task automatic run_op(input string req,
                          input logic [63:0] a, input logic [63:0] c, input logic [63:0] b,
                          input logic [63:0] dp, input logic [2:0] dpf,
                          input logic rec, input logic [3:0] en,
                          input logic [63:0] exp_res, input logic [5:0] exp_flags);
        logic vx, fx, fex;
        logic [63:0] held;
        vx  = |exp_flags[5:3];
        fex = |({vx, exp_flags[2:0]} & en);
        fx  = |(exp_flags & ~m_seen);
        m_seen = m_seen | exp_flags;
        if (rec) m_cr = {fx, fex, vx, exp_flags[2]};
        @(negedge clk);
        op_a = a; op_c = c; op_b = b; dp_result = dp; dp_flags = dpf;
        rec_flag = rec; en_mask = en; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " out_valid R12"}, {63'b0, out_valid}, 64'd1);
        check({req, " result"}, out_res, exp_res);
        check({req, " flags R8"}, {58'b0, out_flags}, {58'b0, exp_flags});
        check({req, " vx R8"}, {63'b0, out_vx}, {63'b0, vx});
        check({req, " fx R9"}, {63'b0, out_fx}, {63'b0, fx});
        check({req, " fex R10"}, {63'b0, out_fex}, {63'b0, fex});
        check({req, " cr R11"}, {60'b0, out_cr}, {60'b0, m_cr});
        held = out_res;
        op_a = ~a; dp_result = ~dp; rec_flag = 1'b1;
        @(negedge clk);
        check({req, " idle valid R12"}, {63'b0, out_valid}, 64'd0);
        check({req, " idle hold R12"}, out_res, held);
        check({req, " idle cr R11"}, {60'b0, out_cr}, {60'b0, m_cr});
    endtask

    task automatic t_reset();
        check("reset valid R12", {63'b0, out_valid}, 64'd0);
        check("reset res R12", out_res, 64'd0);
        check("reset cr R12", {60'b0, out_cr}, 64'd0);
    endtask

    task automatic t_numeric();
        run_op("pos sum R1", ONE, TWO, ONE, 64'h4008_0000_0000_0000, 3'b000, 1'b1, 4'b0000,
               64'hC008_0000_0000_0000, 6'b000000);
        run_op("neg sum inexact R1 R10", ONE, TWO, ONE, 64'hC000_0000_0000_0000, 3'b001, 1'b1, 4'b0001,
               64'h4000_0000_0000_0000, 6'b000001);
        run_op("overflow pass R8", TWO, TWO, ONE, 64'h7FEF_FFFF_FFFF_FFFF, 3'b101, 1'b0, 4'b0100,
               64'hFFEF_FFFF_FFFF_FFFF, 6'b000101);
    endtask

    task automatic t_dp_nan();
        run_op("dp nan sign R2", ONE, TWO, ONE, 64'hFFF8_0000_0000_0001, 3'b000, 1'b0, 4'b0000,
               64'hFFF8_0000_0000_0001, 6'b000000);
        run_op("dp nan pos R2", ONE, ONE, ONE, 64'h7FF8_0000_0000_0123, 3'b000, 1'b1, 4'b0000,
               64'h7FF8_0000_0000_0123, 6'b000000);
    endtask

    task automatic t_imz();
        run_op("zero x inf R3 R8", 64'd0, PINF, ONE, 64'h0000_0000_0000_1234, 3'b111, 1'b1, 4'b0000,
               QNAN0, 6'b010000);
        run_op("inf x negzero R3 R10", NINF, 64'h8000_0000_0000_0000, ONE, 64'd5, 3'b000, 1'b1, 4'b1000,
               QNAN0, 6'b010000);
    endtask

    task automatic t_isi();
        run_op("inf opposite R4", PINF, TWO, NINF, 64'd7, 3'b000, 1'b0, 4'b0000,
               QNAN0, 6'b001000);
        run_op("inf same sign R4", PINF, 64'hC000_0000_0000_0000, NINF, NINF, 3'b000, 1'b0, 4'b0000,
               PINF, 6'b000000);
    endtask

    task automatic t_subnormal();
        run_op("subnormal x inf R7", 64'h0000_0000_0000_0001, PINF, ONE, PINF, 3'b000, 1'b0, 4'b0000,
               NINF, 6'b000000);
    endtask

    task automatic t_nan_ops();
        run_op("snan quieted R5", ONE, 64'h7FF0_0000_0000_0001, ONE, 64'd0, 3'b111, 1'b1, 4'b1000,
               64'h7FF8_0000_0000_0001, 6'b100000);
        run_op("qnan over imz R6", 64'd0, PINF, 64'hFFF8_0000_0000_00AB, 64'd0, 3'b000, 1'b0, 4'b0000,
               64'hFFF8_0000_0000_00AB, 6'b000000);
        run_op("A first R6 R5", 64'hFFF0_0000_0000_0005, 64'h7FF8_0000_0000_000C,
               64'h7FF8_0000_0000_0002, 64'd0, 3'b000, 1'b0, 4'b0000,
               64'hFFF8_0000_0000_0005, 6'b100000);
        run_op("B before C R6", ONE, 64'h7FF0_0000_0000_000C, 64'h7FF8_0000_0000_000B,
               64'd0, 3'b000, 1'b0, 4'b0000, 64'h7FF8_0000_0000_000B, 6'b100000);
    endtask

    task automatic t_history();
        do_reset();
        check("reset clears cr R9", {60'b0, out_cr}, 64'd0);
        run_op("fx after reset R9", PINF, 64'd0, ONE, 64'd0, 3'b000, 1'b1, 4'b0000,
               QNAN0, 6'b010000);
        run_op("fx repeat R9", 64'd0, NINF, ONE, 64'd0, 3'b000, 1'b1, 4'b0000,
               QNAN0, 6'b010000);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0;
        op_a = '0; op_c = '0; op_b = '0; dp_result = '0; dp_flags = '0;
        rec_flag = 1'b0; en_mask = '0;
        m_seen = '0; m_cr = '0;
        do_reset();
        t_reset();
        t_numeric();
        t_dp_nan();
        t_imz();
        t_isi();
        t_subnormal();
        t_nan_ops();
        t_history();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule